// File: doc/BRIEF.md
# Per-Channel Pin Drive and Capture Control

This block is the per-pin logic that sits behind a shared timing generator. The generator sends a bank of phase pulses, each with an assert line and a return line, and a bank of window pulses, each with an open line and a close line. Each channel is tied to one phase and one window through static select inputs. The selection does not change when the timing set in use changes from one vector step to the next.

On the assert pulse of its phase, the channel loads the current vector's pattern bit and drive flag into the driver. On the return pulse, the channel applies its format. Non-return keeps the level. Return-to-zero forces 0 and return-to-one forces 1. On the receive side, the comparator level is captured on either the open or the close pulse of the selected window, depending on the capture mode. A valid flag marks a fresh capture until the next vector boundary.

All outputs are registered. A pulse seen on one rising clock edge is reflected at the outputs directly after that edge.

Top module: `pin_chan_ctrl`

## Requirements
- R1: Only `ph_assert[ph_sel]` and `ph_return[ph_sel]` affect the driver. Pulses on any other phase line leave `drv_lvl` and `drv_en` unchanged.
- R2: Only `win_open[win_sel]` and `win_close[win_sel]` can cause a capture. Pulses on any other window line leave `cap_bit` and `cap_valid` unchanged.
- R3: A selected assert pulse loads `pat_bit` into `drv_lvl` and `pat_drv` into `drv_en`. The new values are visible after the clock edge that samples the pulse.
- R4: A selected return pulse without an assert pulse forces `drv_lvl` to 0 when `fmt` = 2'b01 (return-to-zero) and to 1 when `fmt` = 2'b10 (return-to-one). In both cases `drv_en` is left unchanged.
- R5: A selected return pulse has no effect on `drv_lvl` or `drv_en` when `fmt` = 2'b00 (non-return). The reserved code 2'b11 behaves the same way.
- R6: When the selected assert pulse and the selected return pulse arrive in the same cycle, the assert pulse takes effect and the return pulse is dropped.
- R7: With `cap_mode` = 0 (open edge), the selected open pulse loads `cmp_in` into `cap_bit`, and the selected close pulse is ignored.
- R8: With `cap_mode` = 1 (close edge), the selected close pulse loads `cmp_in` into `cap_bit`, and the selected open pulse is ignored.
- R9: Each sampling pulse sets `cap_valid` to 1 in the next cycle. When `vec_start` arrives without a sampling pulse, `cap_valid` clears and `cap_bit` holds. When a sampling pulse and `vec_start` arrive together, the capture wins.
- R10: After reset, `drv_lvl`, `drv_en`, `cap_bit` and `cap_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_assert | input | NUM_PH | Assert pulses, one per phase |
| ph_return | input | NUM_PH | Return pulses, one per phase |
| win_open | input | NUM_WIN | Open pulses, one per window |
| win_close | input | NUM_WIN | Close pulses, one per window |
| vec_start | input | 1 | Vector boundary pulse |
| ph_sel | input | PH_SEL_W | Phase assigned to this channel |
| win_sel | input | WIN_SEL_W | Window assigned to this channel |
| fmt | input | 2 | Drive format: 00 non-return, 01 return-to-zero, 10 return-to-one, 11 treated as non-return |
| cap_mode | input | 1 | 0 = capture on open pulse, 1 = capture on close pulse |
| pat_bit | input | 1 | Pattern level of the current vector |
| pat_drv | input | 1 | Drive flag of the current vector |
| cmp_in | input | 1 | Comparator level |
| drv_lvl | output | 1 | Level to the pin driver |
| drv_en | output | 1 | Enable to the pin driver |
| cap_bit | output | 1 | Last captured comparator level |
| cap_valid | output | 1 | A capture happened in the current vector |

## Verification
The bound checker inspects every cycle against the selected pulses. It checks that an assert loads the pattern, that each return format gives its level or leaves the driver alone, and that a cycle with no selected phase pulse keeps the driver still. It also checks that a strobe captures the comparator and that a boundary without a strobe clears the valid flag. Whether the right line of each bank is picked, and whether the opposite window edge is ignored in each capture mode, can only be shown by the bench's sweeps. Those sweeps cover every select value against every pulse line and both modes, with expected values computed from the requirements.

// File: rtl/chan_pkg.sv
package chan_pkg;
   typedef enum logic [1:0] {
      FMT_NR   = 2'b00,
      FMT_RZ   = 2'b01,
      FMT_RO   = 2'b10,
      FMT_RSVD = 2'b11
   } fmt_e;

   typedef enum logic {
      CAP_OPEN  = 1'b0,
      CAP_CLOSE = 1'b1
   } cap_mode_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pulse_pick.sv
module pulse_pick #(
   parameter int N = 8,
   localparam int SEL_W = chan_pkg::sel_width(N)
) (
   input  logic [N-1:0]     pulses,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);
   generate
      if (N == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign hit = pulses[0];
      end else if (N == (1 << SEL_W)) begin : g_full
         assign hit = pulses[sel];
      end else begin : g_guarded
         logic [(1 << SEL_W)-1:0] padded;
         assign padded = {{((1 << SEL_W) - N){1'b0}}, pulses};
         assign hit = padded[sel];
      end
   endgenerate
endmodule

// File: rtl/drive_unit.sv
module drive_unit
   import chan_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ast,
   input  logic ret,
   input  fmt_e fmt,
   input  logic pat_bit,
   input  logic pat_drv,
   output logic lvl,
   output logic en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= 1'b0;
         en  <= 1'b0;
      end else if (ast) begin
         lvl <= pat_bit;
         en  <= pat_drv;
      end else if (ret) begin
         case (fmt)
            FMT_RZ:  lvl <= 1'b0;
            FMT_RO:  lvl <= 1'b1;
            default: lvl <= lvl;
         endcase
      end
   end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
   import chan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      open_hit,
   input  logic      close_hit,
   input  cap_mode_e mode,
   input  logic      vec_start,
   input  logic      cmp_in,
   output logic      stb,
   output logic      cap_bit,
   output logic      cap_valid
);
   assign stb = (mode == CAP_CLOSE) ? close_hit : open_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_bit   <= 1'b0;
         cap_valid <= 1'b0;
      end else if (stb) begin
         cap_bit   <= cmp_in;
         cap_valid <= 1'b1;
      end else if (vec_start) begin
         cap_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pin_chan_ctrl.sv
module pin_chan_ctrl
   import chan_pkg::*;
#(
   parameter int NUM_PH  = 8,
   parameter int NUM_WIN = 4,
   localparam int PH_SEL_W  = chan_pkg::sel_width(NUM_PH),
   localparam int WIN_SEL_W = chan_pkg::sel_width(NUM_WIN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PH-1:0]    ph_assert,
   input  logic [NUM_PH-1:0]    ph_return,
   input  logic [NUM_WIN-1:0]   win_open,
   input  logic [NUM_WIN-1:0]   win_close,
   input  logic                 vec_start,
   input  logic [PH_SEL_W-1:0]  ph_sel,
   input  logic [WIN_SEL_W-1:0] win_sel,
   input  logic [1:0]           fmt,
   input  logic                 cap_mode,
   input  logic                 pat_bit,
   input  logic                 pat_drv,
   input  logic                 cmp_in,
   output logic                 drv_lvl,
   output logic                 drv_en,
   output logic                 cap_bit,
   output logic                 cap_valid
);
   generate
      if (NUM_PH < 1 || NUM_PH > 64) begin : g_bad_ph
         $error("pin_chan_ctrl: NUM_PH out of range 1..64");
      end
      if (NUM_WIN < 1 || NUM_WIN > 64) begin : g_bad_win
         $error("pin_chan_ctrl: NUM_WIN out of range 1..64");
      end
   endgenerate

   logic ast_hit, ret_hit, open_hit, close_hit, stb_hit;

   pulse_pick #(.N(NUM_PH)) u_pick_ast (
      .pulses(ph_assert), .sel(ph_sel), .hit(ast_hit));
   pulse_pick #(.N(NUM_PH)) u_pick_ret (
      .pulses(ph_return), .sel(ph_sel), .hit(ret_hit));
   pulse_pick #(.N(NUM_WIN)) u_pick_open (
      .pulses(win_open), .sel(win_sel), .hit(open_hit));
   pulse_pick #(.N(NUM_WIN)) u_pick_close (
      .pulses(win_close), .sel(win_sel), .hit(close_hit));

   drive_unit u_drive (
      .clk(clk), .rst_n(rst_n), .ast(ast_hit), .ret(ret_hit),
      .fmt(fmt_e'(fmt)), .pat_bit(pat_bit), .pat_drv(pat_drv),
      .lvl(drv_lvl), .en(drv_en));

   capture_unit u_cap (
      .clk(clk), .rst_n(rst_n), .open_hit(open_hit), .close_hit(close_hit),
      .mode(cap_mode_e'(cap_mode)), .vec_start(vec_start), .cmp_in(cmp_in),
      .stb(stb_hit), .cap_bit(cap_bit), .cap_valid(cap_valid));
endmodule

// File: rtl/pin_chan_chk.sv
module pin_chan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ast_hit,
   input logic       ret_hit,
   input logic       stb_hit,
   input logic       vec_start,
   input logic [1:0] fmt,
   input logic       pat_bit,
   input logic       pat_drv,
   input logic       cmp_in,
   input logic       drv_lvl,
   input logic       drv_en,
   input logic       cap_bit,
   input logic       cap_valid
);
   // R1
   idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ast_hit && !ret_hit) |=> ($stable(drv_lvl) && $stable(drv_en)));
   // R3
   assert_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ast_hit |=> (drv_lvl == $past(pat_bit) && drv_en == $past(pat_drv)));
   // R4
   rz_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit && !ast_hit && fmt == 2'b01) |=> (!drv_lvl && $stable(drv_en)));
   // R4
   ro_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit && !ast_hit && fmt == 2'b10) |=> (drv_lvl && $stable(drv_en)));
   // R5
   nr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit && !ast_hit && fmt[1] == fmt[0]) |=> ($stable(drv_lvl) && $stable(drv_en)));
   // R9
   strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_hit |=> (cap_valid && cap_bit == $past(cmp_in)));
   // R9
   boundary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_start && !stb_hit) |=> (!cap_valid && $stable(cap_bit)));
   // R2
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_hit && !vec_start) |=> ($stable(cap_bit) && $stable(cap_valid)));
endmodule

bind pin_chan_ctrl pin_chan_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ast_hit(ast_hit), .ret_hit(ret_hit),
   .stb_hit(stb_hit), .vec_start(vec_start), .fmt(fmt), .pat_bit(pat_bit),
   .pat_drv(pat_drv), .cmp_in(cmp_in), .drv_lvl(drv_lvl), .drv_en(drv_en),
   .cap_bit(cap_bit), .cap_valid(cap_valid));

// File: tb/pin_chan_ctrl_bench.sv
module pin_chan_ctrl_bench;
   localparam int NPH = 8;
   localparam int NWN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPH-1:0] ph_assert = '0, ph_return = '0;
   logic [NWN-1:0] win_open = '0, win_close = '0;
   logic vec_start = 1'b0;
   logic [2:0] ph_sel = '0;
   logic [1:0] win_sel = '0;
   logic [1:0] fmt = '0;
   logic cap_mode = 1'b0, pat_bit = 1'b0, pat_drv = 1'b0, cmp_in = 1'b0;
   logic drv_lvl, drv_en, cap_bit, cap_valid;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   logic m_lvl = 0, m_en = 0, m_cb = 0, m_cv = 0;

   always #5 clk = ~clk;

   pin_chan_ctrl u_pin_chan_ctrl (
      .clk(clk), .rst_n(rst_n), .ph_assert(ph_assert), .ph_return(ph_return),
      .win_open(win_open), .win_close(win_close), .vec_start(vec_start),
      .ph_sel(ph_sel), .win_sel(win_sel), .fmt(fmt), .cap_mode(cap_mode),
      .pat_bit(pat_bit), .pat_drv(pat_drv), .cmp_in(cmp_in),
      .drv_lvl(drv_lvl), .drv_en(drv_en), .cap_bit(cap_bit), .cap_valid(cap_valid));

   task automatic check(input string tag);
      total++;
      if ({drv_lvl, drv_en, cap_bit, cap_valid} !== {m_lvl, m_en, m_cb, m_cv}) begin
         bad++;
         $display("FAIL %s: lvl/en/cb/cv actual=%b%b%b%b expected=%b%b%b%b",
                  tag, drv_lvl, drv_en, cap_bit, cap_valid, m_lvl, m_en, m_cb, m_cv);
      end
   endtask

   // inputs are applied at a falling edge, sampled at the rising edge, checked at the next falling edge
   task automatic step(input logic [NPH-1:0] a, input logic [NPH-1:0] r,
                       input logic [NWN-1:0] wo, input logic [NWN-1:0] wc,
                       input logic vs, input logic pb, input logic pd, input logic cm,
                       input string tag);
      logic sa, sr, stb;
      ph_assert = a; ph_return = r; win_open = wo; win_close = wc;
      vec_start = vs; pat_bit = pb; pat_drv = pd; cmp_in = cm;
      sa = a[ph_sel]; sr = r[ph_sel];
      stb = cap_mode ? wc[win_sel] : wo[win_sel];
      if (sa) begin m_lvl = pb; m_en = pd; end
      else if (sr) begin
         if (fmt == 2'b01) m_lvl = 1'b0;
         else if (fmt == 2'b10) m_lvl = 1'b1;
      end
      if (stb) begin m_cb = cm; m_cv = 1'b1; end
      else if (vs) m_cv = 1'b0;
      @(posedge clk);
      @(negedge clk);
      ph_assert = '0; ph_return = '0; win_open = '0; win_close = '0; vec_start = 1'b0;
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10 reset");

      // R1 / R3 / R4: every select against every phase line
      fmt = 2'b01;
      for (int ps = 0; ps < NPH; ps++) begin
         ph_sel = 3'(ps);
         for (int ln = 0; ln < NPH; ln++) begin
            step(8'(1 << ln), '0, '0, '0, 0, 1'((ps + ln) & 1), 1'b1, 0, "R1 R3 assert sweep");
            step('0, 8'(1 << ln), '0, '0, 0, 0, 0, 0, "R1 R4 return sweep");
            step(8'(1 << ln), '0, '0, '0, 0, 1'b1, 1'((ln >> 1) & 1), 0, "R3 enable load");
         end
      end

      // R4 / R5: each format after each pattern level and drive flag
      ph_sel = 3'd5;
      for (int f = 0; f < 4; f++) begin
         fmt = 2'(f);
         for (int p = 0; p < 4; p++) begin
            step(8'h20, '0, '0, '0, 0, 1'(p & 1), 1'(p >> 1), 0, "R3 load before return");
            step('0, 8'h20, '0, '0, 0, 0, 0, 0, (f == 0 || f == 3) ? "R5 nr return" : "R4 rz/ro return");
         end
      end

      // R6: assert and return together
      for (int f = 0; f < 4; f++) begin
         fmt = 2'(f);
         for (int p = 0; p < 2; p++) begin
            step(8'h20, 8'h20, '0, '0, 0, 1'(p), 1'b1, 0, "R6 assert priority");
         end
      end

      // R2 / R7 / R8: every mode, select and window line
      for (int md = 0; md < 2; md++) begin
         cap_mode = 1'(md);
         for (int ws = 0; ws < NWN; ws++) begin
            win_sel = 2'(ws);
            for (int ln = 0; ln < NWN; ln++) begin
               step('0, '0, '0, '0, 1, 0, 0, 0, "R9 boundary clear");
               step('0, '0, 4'(1 << ln), '0, 0, 0, 0, 1'((ln + md) & 1),
                    md ? "R8 open ignored" : "R2 R7 open strobe");
               step('0, '0, '0, 4'(1 << ln), 0, 0, 0, 1'(~((ln + md) & 1)),
                    md ? "R2 R8 close strobe" : "R7 close ignored");
            end
         end
      end

      // R9: boundary with and without a strobe
      cap_mode = 1'b0; win_sel = 2'd2;
      step('0, '0, 4'b0100, '0, 0, 0, 0, 1, "R9 capture one");
      step('0, '0, '0, '0, 1, 0, 0, 0, "R9 boundary keeps bit");
      step('0, '0, 4'b0100, '0, 1, 0, 0, 0, "R9 capture wins over boundary");
      step('0, '0, 4'b0100, '0, 0, 0, 0, 1, "R9 second capture");
      step('0, '0, '0, '0, 0, 0, 0, 0, "R9 hold without strobe");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule